// File: doc/BRIEF.md
# Program ROM bank mapper

This block sits in a cartridge bank controller and turns CPU accesses into 8 KB program ROM page numbers. The upper 32 KB of CPU space is split into four 8 KB slots (0x8000, 0xA000, 0xC000 and 0xE000). The block produces one page index for each slot. It also produces a page index for the 8 KB window at 0x6000, together with a flag that says whether that window is remapped at all.

Software sets up the mapping with ordinary CPU writes. Writes to four addresses load four 8-bit page registers. A write to a fifth address loads a mode register. The mode register selects one of four slot layouts, decides whether the top slot follows a page register or stays on the last page, and enables the remap of the 0x6000 window. Every page index is reduced modulo the ROM size in pages, which is the parameter `NUM_PAGES` and need not be a power of two.

The outputs are combinational functions of the registers. A write is therefore visible at the outputs straight after the clock edge that captures it.

Top module: `prg_bank_mapper`

## Requirements
- R1: While `rst_ni` is low, and after it rises with no writes, page register i (i = 0..3) holds `NUM_PAGES-4+i` and the mode register holds 0. The slots then show pages `NUM_PAGES-4` up to `NUM_PAGES-1` in order, and `low_valid_o` is 0.
- R2: A write with `wr_addr_i` in 0x8000..0x8003 loads page register `wr_addr_i[1:0]` with `wr_data_i`. A write to any other address, except 0xD000, changes no register. Cycles without `wr_en_i` leave the outputs unchanged.
- R3: A write to 0xD000 loads the mode register with these fields:
  - layout = `wr_data_i[1:0]`;
  - top-slot select = `wr_data_i[2]`;
  - low-window remap enable = `wr_data_i[7]`.
  Bits 6:3 of the data have no effect.
- R4: In layout 0, slot s shows page `NUM_PAGES-4+s`, whatever the page registers hold.
- R5: In layout 1, slots 0 and 1 show `2*P1` and `2*P1+1` (P1 is page register 1), and slots 2 and 3 show `NUM_PAGES-2` and `NUM_PAGES-1`.
- R6: In layout 2, slots 0..2 show page registers 0..2. Slot 3 shows page register 3 when the top-slot select is 1.
- R7: In layout 2 with the top-slot select at 0, slot 3 shows `NUM_PAGES-1`.
- R8: `low_valid_o` is 1 only in layout 2 with the top-slot select at 0 and the remap enable at 1. In that case `low_page_o` shows page register 3; otherwise `low_page_o` is 0.
- R9: In layout 3, slots 0..3 show page registers 3, 2, 1, 0 in that order.
- R10: Every page index shown is the computed value modulo `NUM_PAGES`, so it is always below `NUM_PAGES`.
- R11: A register write is visible at the outputs right after the rising edge that captures it, with no further cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| slot_page_o | output | 4 x PAGE_W | Page index for each upper 8 KB slot; element s is slot s |
| low_valid_o | output | 1 | The 0x6000 window is remapped |
| low_page_o | output | PAGE_W | Page index for the 0x6000 window |

## Verification
The outputs are purely combinational from the registers, so a wrong page register or mode field shows at the ports on the first cycle after the write that caused it. It stays visible until the next write to the same register. A field decoded from the wrong data bit shows up as the wrong layout or a wrong `low_valid_o`. A decode that matches too many addresses shows up as a changed slot after a write that should have been ignored. A missing or wrong modulo reduction is exposed by page values at or above `NUM_PAGES`, using a default ROM size that is not a power of two.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

  localparam logic [15:0] PAGE_REG_BASE = 16'h8000;
  localparam logic [15:0] MODE_REG_ADDR = 16'hD000;

  typedef enum logic [1:0] {
    LAYOUT_FIXED   = 2'd0,
    LAYOUT_PAIR    = 2'd1,
    LAYOUT_DIRECT  = 2'd2,
    LAYOUT_REVERSE = 2'd3
  } layout_e;

  typedef struct packed {
    logic    low_remap;
    logic    top_sel;
    layout_e layout;
  } mode_t;

endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 24,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   page_q_o,
  output mode_t                             mode_q_o
);

  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic page_hit;
  logic mode_hit;
  logic unused_data_bits;

  assign page_hit = wr_en_i &&
                    (wr_addr_i[ADDR_W-1:SEL_W] == PAGE_REG_BASE[ADDR_W-1:SEL_W]);
  assign mode_hit = wr_en_i && (wr_addr_i == MODE_REG_ADDR);

  // Data bits 6:3 carry no mode field
  assign unused_data_bits = ^wr_data_i[6:3];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_page
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(NUM_PAGES - NUM_REGS + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_q_o[i] <= RST_VAL;
      end else if (page_hit && (wr_addr_i[SEL_W-1:0] == SEL_W'(i))) begin
        page_q_o[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= '0;
    end else if (mode_hit) begin
      mode_q_o.layout    <= layout_e'(wr_data_i[1:0]);
      mode_q_o.top_sel   <= wr_data_i[2];
      mode_q_o.low_remap <= wr_data_i[7];
    end
  end

endmodule

// File: rtl/prg_bank_layout.sv
module prg_bank_layout
  import prg_bank_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 24,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] page_q_i,
  input  mode_t                            mode_i,
  output logic [NUM_SLOTS-1:0][PAGE_W-1:0] slot_page_o,
  output logic                             low_valid_o,
  output logic [PAGE_W-1:0]                low_page_o
);

  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  function automatic logic [PAGE_W-1:0] wrap(input logic [DATA_W:0] v);
    return PAGE_W'(32'(v) % NUM_PAGES);
  endfunction

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [PAGE_W-1:0] FIX_PAGE = PAGE_W'(NUM_PAGES - NUM_SLOTS + s);
    logic [PAGE_W-1:0] pair_page;
    logic [PAGE_W-1:0] direct_page;
    logic [PAGE_W-1:0] rev_page;

    // Only the two lowest slots follow the doubled register
    if (s < 2) begin : g_pair
      assign pair_page = wrap({page_q_i[1], 1'b0} + (DATA_W + 1)'(s));
    end else begin : g_pair_fix
      assign pair_page = FIX_PAGE;
    end

    if (s == NUM_SLOTS - 1) begin : g_top
      assign direct_page = mode_i.top_sel ? wrap({1'b0, page_q_i[s]}) : LAST_PAGE;
    end else begin : g_low
      assign direct_page = wrap({1'b0, page_q_i[s]});
    end

    assign rev_page = wrap({1'b0, page_q_i[NUM_SLOTS-1-s]});

    always_comb begin
      unique case (mode_i.layout)
        LAYOUT_FIXED:   slot_page_o[s] = FIX_PAGE;
        LAYOUT_PAIR:    slot_page_o[s] = pair_page;
        LAYOUT_DIRECT:  slot_page_o[s] = direct_page;
        LAYOUT_REVERSE: slot_page_o[s] = rev_page;
        default:        slot_page_o[s] = FIX_PAGE;
      endcase
    end
  end

  assign low_valid_o = (mode_i.layout == LAYOUT_DIRECT) && !mode_i.top_sel && mode_i.low_remap;
  assign low_page_o  = low_valid_o ? wrap({1'b0, page_q_i[NUM_SLOTS-1]}) : '0;

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_bank_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 24,
  localparam int unsigned NUM_SLOTS = 4,
  localparam int unsigned DATA_W    = 8,
  localparam int unsigned ADDR_W    = 16,
  localparam int unsigned PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_SLOTS-1:0][PAGE_W-1:0] slot_page_o,
  output logic                             low_valid_o,
  output logic [PAGE_W-1:0]                low_page_o
);

  logic [NUM_SLOTS-1:0][DATA_W-1:0] page_q;
  mode_t                            mode_q;
  logic [1:0]                       cur_layout;
  logic                             cur_top_sel;
  logic                             cur_low_remap;

  prg_bank_regs #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_REGS  (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .page_q_o  (page_q),
    .mode_q_o  (mode_q)
  );

  prg_bank_layout #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W)
  ) u_layout (
    .page_q_i    (page_q),
    .mode_i      (mode_q),
    .slot_page_o (slot_page_o),
    .low_valid_o (low_valid_o),
    .low_page_o  (low_page_o)
  );

  assign cur_layout    = mode_q.layout;
  assign cur_top_sel   = mode_q.top_sel;
  assign cur_low_remap = mode_q.low_remap;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int unsigned NUM_PAGES = 24,
  localparam int unsigned PAGE_W   = $clog2(NUM_PAGES)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [15:0]              wr_addr_i,
  input logic [7:0]               wr_data_i,
  input logic [3:0][PAGE_W-1:0]   slot_page_o,
  input logic                     low_valid_o,
  input logic [PAGE_W-1:0]        low_page_o,
  input logic [1:0]               cur_layout,
  input logic                     cur_top_sel,
  input logic                     cur_low_remap
);

  // R10
  pages_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(slot_page_o[0]) < NUM_PAGES) && (32'(slot_page_o[1]) < NUM_PAGES) &&
    (32'(slot_page_o[2]) < NUM_PAGES) && (32'(slot_page_o[3]) < NUM_PAGES) &&
    (32'(low_page_o) < NUM_PAGES));

  // R4
  fixed_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_layout == 2'd0) |->
      (32'(slot_page_o[0]) == NUM_PAGES - 4) && (32'(slot_page_o[3]) == NUM_PAGES - 1));

  // R7
  top_slot_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_layout == 2'd2 && !cur_top_sel) |-> (32'(slot_page_o[3]) == NUM_PAGES - 1));

  // R8
  low_valid_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_valid_o |-> (cur_layout == 2'd2) && !cur_top_sel && cur_low_remap);

  // R8
  low_page_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_valid_o |-> (low_page_o == '0));

  // R2
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(slot_page_o) && $stable(low_page_o) && $stable(low_valid_o));

  // R11
  mode_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 16'hD000) |=>
      (cur_layout == $past(wr_data_i[1:0])) && (cur_top_sel == $past(wr_data_i[2])) &&
      (cur_low_remap == $past(wr_data_i[7])));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .slot_page_o   (slot_page_o),
  .low_valid_o   (low_valid_o),
  .low_page_o    (low_page_o),
  .cur_layout    (cur_layout),
  .cur_top_sel   (cur_top_sel),
  .cur_low_remap (cur_low_remap)
);

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 24;
  localparam int PW         = $clog2(NP);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_en = 1'b0;
  logic [15:0]          wr_addr = '0;
  logic [7:0]           wr_data = '0;
  logic [3:0][PW-1:0]   slot_page;
  logic                 low_valid;
  logic [PW-1:0]        low_page;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int pr [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper #(.NUM_PAGES(NP)) u_prg_bank_mapper (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .slot_page_o (slot_page),
    .low_valid_o (low_valid),
    .low_page_o  (low_page)
  );

  function automatic int md(input int v);
    return v % NP;
  endfunction

  // Drive at negedge, capture at posedge, return at the following negedge
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 16'h8000 && a <= 16'h8003) pr[a[1:0]] = int'(d);
  endtask

  task automatic check_slots(input string req, input int e0, input int e1,
                             input int e2, input int e3);
    int exp_v [4];
    exp_v = '{e0, e1, e2, e3};
    for (int s = 0; s < 4; s++) begin
      checks++;
      if (int'(slot_page[s]) != exp_v[s]) begin
        errors++;
        $display("FAIL %s slot%0d actual %0d expected %0d", req, s, slot_page[s], exp_v[s]);
      end
    end
  endtask

  task automatic check_low(input string req, input bit ev, input int ep);
    checks++;
    if (low_valid !== ev || int'(low_page) != ep) begin
      errors++;
      $display("FAIL %s low actual %0b/%0d expected %0b/%0d", req, low_valid, low_page, ev, ep);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) pr[i] = NP - 4 + i;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_slots("R1", NP-4, NP-3, NP-2, NP-1);
    check_low("R1", 1'b0, 0);
  endtask

  task automatic t_fixed_layout();
    cpu_write(16'h8000, 8'd5);
    cpu_write(16'h8001, 8'd6);
    cpu_write(16'h8002, 8'd7);
    cpu_write(16'h8003, 8'd8);
    check_slots("R4", NP-4, NP-3, NP-2, NP-1);
  endtask

  task automatic t_reverse();
    cpu_write(16'hD000, 8'h03);
    // Sampled right after the capturing edge
    check_slots("R9 R11", pr[3], pr[2], pr[1], pr[0]);
    check_low("R9", 1'b0, 0);
  endtask

  task automatic t_decode();
    cpu_write(16'h8004, 8'd1);
    cpu_write(16'h7FFF, 8'd2);
    cpu_write(16'hD001, 8'h00);
    cpu_write(16'hC003, 8'd3);
    check_slots("R2 ignored", 8, 7, 6, 5);
    cpu_write(16'h8002, 8'd9);
    check_slots("R2 reg2", 8, 9, 6, 5);
  endtask

  task automatic t_field_bits();
    cpu_write(16'hD000, 8'h7B);
    check_slots("R3 bits6..3", pr[3], pr[2], pr[1], pr[0]);
    check_low("R3", 1'b0, 0);
  endtask

  task automatic t_pair();
    cpu_write(16'hD000, 8'h81);
    cpu_write(16'h8001, 8'd13);
    check_slots("R5 R10 wrap", md(26), md(27), NP-2, NP-1);
    check_low("R8 layout1", 1'b0, 0);
    cpu_write(16'h8001, 8'd5);
    check_slots("R5", 10, 11, NP-2, NP-1);
  endtask

  task automatic t_direct();
    cpu_write(16'h8000, 8'd30);
    cpu_write(16'h8003, 8'd255);
    cpu_write(16'hD000, 8'h86);
    check_slots("R6 R10", md(30), pr[1], pr[2], md(255));
    check_low("R8 topsel", 1'b0, 0);
    cpu_write(16'hD000, 8'h82);
    check_slots("R7", md(30), pr[1], pr[2], NP-1);
    check_low("R8 remap", 1'b1, md(255));
    cpu_write(16'h8003, 8'd4);
    check_low("R8 R11 reg3", 1'b1, 4);
    cpu_write(16'hD000, 8'h02);
    check_low("R8 no remap", 1'b0, 0);
    check_slots("R7 no remap", md(30), pr[1], pr[2], NP-1);
  endtask

  task automatic t_idle();
    repeat (5) @(negedge clk);
    check_slots("R2 idle", md(30), pr[1], pr[2], NP-1);
  endtask

  initial begin
    t_reset();
    t_fixed_layout();
    t_reverse();
    t_decode();
    t_field_bits();
    t_pair();
    t_direct();
    t_idle();
    t_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule